// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two phase-shifted channels of an incremental rotary encoder into a signed shaft position. Each raw channel is first brought into the clock domain and then cleaned by a glitch filter. The filter only acts on clock cycles where a separate slow tick input is high, so the shortest pulse it rejects can be set independently of the main clock. The cleaned pair is decoded on every edge of either channel, which gives four counts per encoder line. The phase order of the two channels sets the direction of each count.

A 16-bit two's complement counter accumulates the counts. When a sample strobe arrives, the block stores the difference between the current position and the position taken at the previous strobe. This serves as a per-sample speed estimate for a control loop. If both cleaned channels change on the same clock, the block cannot tell the direction. It then discards the step and sets a flag that stays set until reset.

Top module: `quad_position_tracker`

## Requirements
- R1: A raw channel level reaches the decoder only after the synchronized input has differed from the current clean level on FILT_LEN consecutive tick cycles (default 4). Any shorter excursion leaves position and countPulse unchanged.
- R2: Every legal change of the clean channel pair is exactly one count: a step of one bit in {A,B}. A full encoder cycle gives four counts.
- R3: When A leads B, the {A,B} sequence 00, 10, 11, 01 counts up and direction reads 1. The reverse order counts down and direction reads 0.
- R4: If both clean bits change on the same clock, position stays where it is, no countPulse is produced, and stepError goes to 1. stepError then holds at 1 until reset, including through later legal steps.
- R5: position is a 16-bit two's complement value that wraps. Counting down from 0 gives 16'hFFFF.
- R6: In the cycle after sampleStrobe is high, velocity equals position minus the position captured at the previous strobe, modulo 2^16. Between strobes, velocity holds its value.
- R7: countPulse is high for exactly one clock on each count, in the same clock in which position changes by one. Position never changes when countPulse is low.
- R8: After reset, position, velocity, countPulse and stepError are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| filtTick | input | 1 | Enable for the glitch filters, one clock wide |
| rawA | input | 1 | Encoder channel A, asynchronous |
| rawB | input | 1 | Encoder channel B, asynchronous |
| sampleStrobe | input | 1 | Captures a new velocity value |
| position | output | 16 | Signed position count |
| velocity | output | 16 | Position change over the last sample interval |
| countPulse | output | 1 | One-clock pulse per decoded count |
| direction | output | 1 | Direction of the most recent count, 1 = up |
| stepError | output | 1 | Sticky flag for a simultaneous change of both channels |

## Verification
Forward and reverse quadrature sequences are applied to separate the up and down decode. A backward run that crosses zero shows the wrap and the modular velocity difference. A thirteen-edge run with three short pulses injected on A must land exactly thirteen counts further on; this separates glitch rejection from real edges. Pulses held for two or three ticks are checked against the filter length. A simultaneous flip of both channels, followed by legal steps, shows that the step is dropped and that the error flag stays set.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic countUp;
    logic sampleEn;
  } qptStrobe_t;

  typedef logic [1:0] abState_t; // {A,B}
endpackage

// File: rtl/qpt_glitch_filter.sv
module qpt_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       holdCnt;
  logic                   syncIn;

  assign syncIn = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  // accept a new level after FILT_LEN consecutive ticks of disagreement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt  <= '0;
      cleanOut <= 1'b0;
    end else if (syncIn == cleanOut) begin
      holdCnt <= '0;
    end else if (tick) begin
      if (holdCnt == LAST) begin
        cleanOut <= syncIn;
        holdCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpt_control.sv
module qpt_control
  import qpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  abState_t   cleanAB,
  input  logic       sampleStrobe,
  output qptStrobe_t strobe,
  output logic       countPulse,
  output logic       direction,
  output logic       stepError
);
  abState_t prevAB;
  abState_t changed;

  assign changed = prevAB ^ cleanAB;

  always_comb begin
    strobe.countEn  = (changed == 2'b01) || (changed == 2'b10);
    // A leads B: new A differs from old B
    strobe.countUp  = cleanAB[1] ^ prevAB[0];
    strobe.sampleEn = sampleStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAB     <= '0;
      countPulse <= 1'b0;
      direction  <= 1'b0;
      stepError  <= 1'b0;
    end else begin
      prevAB     <= cleanAB;
      countPulse <= strobe.countEn;
      if (strobe.countEn) direction <= strobe.countUp;
      if (changed == 2'b11) stepError <= 1'b1;
    end
  end
endmodule

// File: rtl/qpt_datapath.sv
module qpt_datapath
  import qpt_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qptStrobe_t       strobe,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] velocity
);
  logic [POS_W-1:0] lastSample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      position <= '0;
    end else if (strobe.countEn) begin
      if (strobe.countUp) position <= position + 1'b1;
      else                position <= position - 1'b1;
    end
  end

  // modular first difference per sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSample <= '0;
      velocity   <= '0;
    end else if (strobe.sampleEn) begin
      velocity   <= position - lastSample;
      lastSample <= position;
    end
  end
endmodule

// File: rtl/quad_position_tracker.sv
module quad_position_tracker
  import qpt_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             filtTick,
  input  logic             rawA,
  input  logic             rawB,
  input  logic             sampleStrobe,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] velocity,
  output logic             countPulse,
  output logic             direction,
  output logic             stepError
);
  abState_t   rawAB;
  abState_t   cleanAB;
  qptStrobe_t strobe;

  assign rawAB = {rawA, rawB};

  for (genvar ch = 0; ch < 2; ch++) begin : g_filt
    qpt_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .tick(filtTick),
      .rawIn(rawAB[ch]), .cleanOut(cleanAB[ch])
    );
  end

  qpt_control u_ctrl (
    .clk(clk), .rstN(rstN), .cleanAB(cleanAB), .sampleStrobe(sampleStrobe),
    .strobe(strobe), .countPulse(countPulse), .direction(direction),
    .stepError(stepError)
  );

  qpt_datapath #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .position(position), .velocity(velocity)
  );
endmodule

// File: rtl/qpt_checker.sv
module qpt_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStrobe,
  input logic [POS_W-1:0] position,
  input logic [POS_W-1:0] velocity,
  input logic             countPulse,
  input logic             direction,
  input logic             stepError
);
  logic [POS_W-1:0] prevPos;
  logic [POS_W-1:0] delta;

  always_ff @(posedge clk) begin
    if (!rstN) prevPos <= '0;
    else       prevPos <= position;
  end
  assign delta = position - prevPos;

  AST_STEP_IS_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    (delta != '0) |-> (delta == POS_W'(1) || delta == '1)); // R2
  AST_DIR_MATCHES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> (direction ? (delta == POS_W'(1)) : (delta == '1))); // R3
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stepError |=> stepError); // R4
  AST_VEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(velocity)); // R6
  AST_NO_SILENT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !countPulse |-> (delta == '0)); // R7
endmodule

bind quad_position_tracker qpt_checker #(.POS_W(POS_W)) u_qptChk (
  .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
  .position(position), .velocity(velocity), .countPulse(countPulse),
  .direction(direction), .stepError(stepError)
);

// File: tb/quad_position_tracker_bench.sv
`timescale 1ns/1ps
module quad_position_tracker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        filtTick = 1'b0;
  logic        rawA = 1'b0;
  logic        rawB = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] position;
  logic [15:0] velocity;
  logic        countPulse;
  logic        direction;
  logic        stepError;

  int errors = 0;
  int checks = 0;
  int pulseSeen = 0;
  int tickDiv = 0;
  int seqIdx = 0;       // index into 00,10,11,01
  logic [15:0] expPos = '0;

  always #2.5 clk = ~clk; // 200 MHz

  quad_position_tracker u_quad_position_tracker (
    .clk(clk), .rstN(rstN), .filtTick(filtTick), .rawA(rawA), .rawB(rawB),
    .sampleStrobe(sampleStrobe), .position(position), .velocity(velocity),
    .countPulse(countPulse), .direction(direction), .stepError(stepError)
  );

  // filter tick: one clock in four
  always @(negedge clk) begin
    tickDiv  <= (tickDiv + 1) % 4;
    filtTick <= (tickDiv == 3);
  end

  always @(posedge clk) if (rstN && countPulse) pulseSeen <= pulseSeen + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] seqAB(input int idx);
    case (((idx % 4) + 4) % 4)
      0: seqAB = 2'b00;
      1: seqAB = 2'b10;
      2: seqAB = 2'b11;
      default: seqAB = 2'b01;
    endcase
  endfunction

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic step(input bit up);
    logic [1:0] ab;
    seqIdx = up ? seqIdx + 1 : seqIdx - 1;
    ab = seqAB(seqIdx);
    rawA = ab[1];
    rawB = ab[0];
    expPos = up ? expPos + 16'd1 : expPos - 16'd1;
    settle();
  endtask

  task automatic glitchA(input int len);
    rawA = ~rawA;
    repeat (len) @(negedge clk);
    rawA = ~rawA;
    settle();
  endtask

  task automatic sample();
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(position == 16'd0, "R8 position", position, 0);
    check(velocity == 16'd0, "R8 velocity", velocity, 0);
    check(countPulse == 1'b0 && stepError == 1'b0, "R8 flags",
          {countPulse, stepError}, 0);
  endtask

  task automatic testForward();
    int startPulses = pulseSeen;
    sample();
    for (int i = 0; i < 4; i++) step(1'b1);
    check(position == 16'd4, "R2 four counts per cycle", position, 4);
    check(direction == 1'b1, "R3 up direction", direction, 1);
    check(pulseSeen - startPulses == 4, "R7 pulse per count", pulseSeen - startPulses, 4);
    sample();
    check(velocity == 16'd4, "R6 velocity forward", velocity, 4);
  endtask

  task automatic testReverseWrap();
    for (int i = 0; i < 6; i++) step(1'b0);
    check(position == 16'hFFFE, "R5 wrap below zero", position, 16'hFFFE);
    check(direction == 1'b0, "R3 down direction", direction, 0);
    sample();
    check(velocity == 16'hFFFA, "R6 velocity across wrap", velocity, 16'hFFFA);
    step(1'b1);
    check(velocity == 16'hFFFA, "R6 velocity holds between strobes", velocity, 16'hFFFA);
  endtask

  task automatic testGlitches();
    logic [15:0] startPos = position;
    int startPulses = pulseSeen;
    for (int i = 0; i < 13; i++) begin
      step(1'b1);
      if (i == 2 || i == 6 || i == 10) glitchA(5);
    end
    check(position == startPos + 16'd13, "R1 thirteen edges with glitches",
          position, startPos + 16'd13);
    check(pulseSeen - startPulses == 13, "R7 glitch pulses", pulseSeen - startPulses, 13);
    startPos = position;
    glitchA(11); // up to three ticks, below FILT_LEN
    check(position == startPos, "R1 three-tick pulse rejected", position, startPos);
  endtask

  task automatic testIllegal();
    logic [15:0] startPos = position;
    logic [1:0] ab;
    int startPulses = pulseSeen;
    seqIdx = seqIdx + 2;
    ab = seqAB(seqIdx);
    rawA = ab[1];
    rawB = ab[0];
    settle();
    check(position == startPos, "R4 double change ignored", position, startPos);
    check(pulseSeen == startPulses, "R4 no pulse on double change", pulseSeen - startPulses, 0);
    check(stepError == 1'b1, "R4 error set", stepError, 1);
    step(1'b1);
    step(1'b0);
    check(stepError == 1'b1, "R4 error sticky", stepError, 1);
    check(position == expPos, "R2 counting after error", position, expPos);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testForward();
    testReverseWrap();
    testGlitches();
    testIllegal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule